// File: doc/BRIEF.md
# Serial Audio Receiver with Automatic Word-Length Detection

This block takes a two-channel serial audio stream in the common inter-IC sound format, made of a bit clock, a word-select line and a data line, and rebuilds one left and one right sample per frame. The three serial lines come from an external source and are not related to the block's system clock. They are brought into the system clock domain through synchronisers. Each rising edge of the bit clock is then found as a one-cycle strobe.

No word length is configured. The receiver counts the bit clocks in each word-select half-period and treats that count, limited to 24, as the word length. It places each sample at the top of a 24-bit output word and fills the unused low bits with zeros. Once a right word is complete, it presents the finished pair together with the detected length and a one-cycle valid strobe. A half-period that is too short to hold a sample raises a format-error strobe, and no sample is issued for that frame.

Top module: `i2s_autolen_rx`

## Requirements
- R1: After reset, `left_o`, `right_o` and `len_o` are zero and neither strobe fires. The partial word in progress before the first word-select transition seen after reset is discarded.
- R2: Data is sent MSB first. The MSB of a word is sampled on the second rising bit-clock edge after a word-select change, and the LSB is sampled on the edge that sees the next change. A 24-bit word is reproduced exactly.
- R3: A 16-bit word is output as its 16 bits in output bits 23..8, with bits 7..0 set to zero. `len_o` reads 16.
- R4: Any length from 16 to 24 is detected. `len_o` equals the number of bit-clock edges in the right half-period, and a frame is only issued when both halves hold at least 16 edges.
- R5: In a half-period longer than 24 bit clocks, only the first 24 bits are kept. The rest are ignored and `len_o` reads 24.
- R6: `frame_vld_o` pulses high for exactly one cycle per completed left/right pair, after the right word has been captured. Between pulses the three data outputs hold their values.
- R7: Bits sampled while word-select is 0 belong to the left word (`left_o`). Bits sampled while it is 1 belong to the right word (`right_o`).
- R8: A half-period with fewer than 16 bit clocks pulses `fmt_err_o` for one cycle. No `frame_vld_o` is produced for that frame, and the outputs keep their previous values. The error strobe and the valid strobe never coincide.
- R9: A short left half cancels the pairing. The receiver recovers by itself on the next well-formed frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sclk_i | input | 1 | Serial bit clock, asynchronous |
| lrck_i | input | 1 | Word select: 0 = left, 1 = right |
| sdata_i | input | 1 | Serial data, MSB first |
| left_o | output | SAMPLE_W | Left sample, left-justified and zero padded |
| right_o | output | SAMPLE_W | Right sample, left-justified and zero padded |
| len_o | output | $clog2(SAMPLE_W+1) | Detected word length of the issued frame |
| frame_vld_o | output | 1 | One-cycle strobe: a new left/right pair is on the outputs |
| fmt_err_o | output | 1 | One-cycle strobe: a half-period was shorter than 16 bits |

## Verification
The stimulus table sends frames with word slots of 16, 17, 18, 20, 24 and 32 bits. Each uses distinct bit patterns in the two channels, so a swapped channel, a shifted MSB position, a missing zero pad or a wrong saturation point each shows up as a different wrong value. The directed frames use a 12-bit left half and a 15-bit right half, one bit below the threshold. They show whether the error strobe fires, whether the outputs hold and whether the valid count stays the same. A well-formed frame sent afterwards shows that the receiver recovers. A reset in the middle of a run, followed by a fresh preamble, shows that the outputs clear and that the partial word after reset is dropped.

// File: rtl/i2s_rx_pkg.sv
package i2s_rx_pkg;
   typedef enum logic {
      CH_LEFT  = 1'b0,
      CH_RIGHT = 1'b1
   } chan_e;
endpackage

// File: rtl/i2s_rx_sync.sv
module i2s_rx_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (STAGES < 0 || STAGES > 4) begin : g_bad
         $error("i2s_rx_sync: STAGES must be 0..4");
      end
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [W-1:0] stg [STAGES];
         for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
               if (!rst_n) stg[s] <= '0;
               else if (s == 0) stg[s] <= d_i;
               else stg[s] <= stg[(s == 0) ? 0 : s-1];
            end
         end
         assign q_o = stg[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/i2s_rx_edge.sv
module i2s_rx_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic level_i,
   output logic rise_o
);
   logic level_q;
   always_ff @(posedge clk) begin
      if (!rst_n) level_q <= 1'b0;
      else level_q <= level_i;
   end
   assign rise_o = level_i & ~level_q;
endmodule

// File: rtl/i2s_rx_word_asm.sv
module i2s_rx_word_asm #(
   parameter int SAMPLE_W = 24,
   localparam int CNT_W   = $clog2(SAMPLE_W + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                strobe_i,
   input  logic                lr_i,
   input  logic                bit_i,
   output logic                done_o,
   output logic [SAMPLE_W-1:0] data_o,
   output logic [CNT_W-1:0]    len_o,
   output i2s_rx_pkg::chan_e   chan_o
);
   import i2s_rx_pkg::*;
   localparam logic [CNT_W-1:0] FULL = CNT_W'(SAMPLE_W);

   logic [SAMPLE_W-1:0] acc, acc_nxt;
   logic [CNT_W-1:0]    cnt, cnt_nxt;
   logic                lr_prev, seen, armed, boundary;

   always_comb begin
      acc_nxt = acc;
      for (int k = 0; k < SAMPLE_W; k++) begin
         if (CNT_W'(SAMPLE_W - 1 - k) == cnt) acc_nxt[k] = bit_i;
      end
      cnt_nxt = (cnt == FULL) ? cnt : cnt + 1'b1;
   end

   assign boundary = strobe_i & seen & (lr_i != lr_prev);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc     <= '0;
         cnt     <= '0;
         lr_prev <= 1'b0;
         seen    <= 1'b0;
         armed   <= 1'b0;
         done_o  <= 1'b0;
         data_o  <= '0;
         len_o   <= '0;
         chan_o  <= CH_LEFT;
      end else begin
         done_o <= 1'b0;
         if (strobe_i) begin
            lr_prev <= lr_i;
            seen    <= 1'b1;
            if (boundary) begin
               done_o <= armed;
               data_o <= acc_nxt;
               len_o  <= cnt_nxt;
               chan_o <= chan_e'(lr_prev);
               acc    <= '0;
               cnt    <= '0;
               armed  <= 1'b1;
            end else begin
               acc <= acc_nxt;
               cnt <= cnt_nxt;
            end
         end
      end
   end
endmodule

// File: rtl/i2s_rx_pair.sv
module i2s_rx_pair #(
   parameter int SAMPLE_W = 24,
   parameter int MIN_BITS = 16,
   localparam int CNT_W   = $clog2(SAMPLE_W + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                done_i,
   input  logic [SAMPLE_W-1:0] data_i,
   input  logic [CNT_W-1:0]    len_i,
   input  i2s_rx_pkg::chan_e   chan_i,
   output logic [SAMPLE_W-1:0] left_o,
   output logic [SAMPLE_W-1:0] right_o,
   output logic [CNT_W-1:0]    len_o,
   output logic                frame_vld_o,
   output logic                fmt_err_o
);
   import i2s_rx_pkg::*;
   logic [SAMPLE_W-1:0] pend;
   logic                left_ok, too_short;

   assign too_short = len_i < CNT_W'(MIN_BITS);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend        <= '0;
         left_ok     <= 1'b0;
         left_o      <= '0;
         right_o     <= '0;
         len_o       <= '0;
         frame_vld_o <= 1'b0;
         fmt_err_o   <= 1'b0;
      end else begin
         frame_vld_o <= 1'b0;
         fmt_err_o   <= 1'b0;
         if (done_i) begin
            if (too_short) begin
               fmt_err_o <= 1'b1;
               left_ok   <= 1'b0;
            end else if (chan_i == CH_LEFT) begin
               pend    <= data_i;
               left_ok <= 1'b1;
            end else begin
               left_ok <= 1'b0;
               if (left_ok) begin
                  left_o      <= pend;
                  right_o     <= data_i;
                  len_o       <= len_i;
                  frame_vld_o <= 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/i2s_autolen_rx.sv
module i2s_autolen_rx #(
   parameter int SAMPLE_W    = 24,
   parameter int MIN_BITS    = 16,
   parameter int SYNC_STAGES = 2,
   localparam int LEN_W      = $clog2(SAMPLE_W + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sclk_i,
   input  logic                lrck_i,
   input  logic                sdata_i,
   output logic [SAMPLE_W-1:0] left_o,
   output logic [SAMPLE_W-1:0] right_o,
   output logic [LEN_W-1:0]    len_o,
   output logic                frame_vld_o,
   output logic                fmt_err_o
);
   import i2s_rx_pkg::*;

   generate
      if (MIN_BITS < 1 || MIN_BITS > SAMPLE_W) begin : g_bad_min
         $error("i2s_autolen_rx: MIN_BITS must be 1..SAMPLE_W");
      end
   endgenerate

   logic [2:0] raw, syn;
   logic       bit_stb, w_done;
   logic [SAMPLE_W-1:0] w_data;
   logic [LEN_W-1:0]    w_len;
   chan_e               w_chan;

   assign raw = {sclk_i, lrck_i, sdata_i};

   i2s_rx_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(raw), .q_o(syn));

   i2s_rx_edge u_edge (
      .clk(clk), .rst_n(rst_n), .level_i(syn[2]), .rise_o(bit_stb));

   i2s_rx_word_asm #(.SAMPLE_W(SAMPLE_W)) u_asm (
      .clk(clk), .rst_n(rst_n), .strobe_i(bit_stb),
      .lr_i(syn[1]), .bit_i(syn[0]),
      .done_o(w_done), .data_o(w_data), .len_o(w_len), .chan_o(w_chan));

   i2s_rx_pair #(.SAMPLE_W(SAMPLE_W), .MIN_BITS(MIN_BITS)) u_pair (
      .clk(clk), .rst_n(rst_n), .done_i(w_done), .data_i(w_data),
      .len_i(w_len), .chan_i(w_chan),
      .left_o(left_o), .right_o(right_o), .len_o(len_o),
      .frame_vld_o(frame_vld_o), .fmt_err_o(fmt_err_o));
endmodule

// File: rtl/i2s_rx_chk.sv
module i2s_rx_chk #(
   parameter int SAMPLE_W = 24,
   parameter int MIN_BITS = 16,
   localparam int LEN_W   = $clog2(SAMPLE_W + 1)
) (
   input logic                clk,
   input logic                rst_n,
   input logic [SAMPLE_W-1:0] left_o,
   input logic [SAMPLE_W-1:0] right_o,
   input logic [LEN_W-1:0]    len_o,
   input logic                frame_vld_o,
   input logic                fmt_err_o
);
   localparam logic [SAMPLE_W-1:0] ALL = '1;

   // R6: one-cycle valid strobe
   a_r6_vld_single: assert property (@(posedge clk) disable iff (!rst_n)
      frame_vld_o |=> !frame_vld_o);

   // R6: outputs hold between strobes
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_vld_o |-> ($stable(left_o) && $stable(right_o) && $stable(len_o)));

   // R8: error and valid never together
   a_r8_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
      fmt_err_o |-> !frame_vld_o);

   // R4 / R5: issued length lies in the legal range
   a_r4_len_range: assert property (@(posedge clk) disable iff (!rst_n)
      frame_vld_o |-> (len_o >= LEN_W'(MIN_BITS) && len_o <= LEN_W'(SAMPLE_W)));

   // R3: bits below the detected length are zero
   a_r3_pad: assert property (@(posedge clk) disable iff (!rst_n)
      frame_vld_o |-> ((right_o & (ALL >> len_o)) == '0));
endmodule

bind i2s_autolen_rx i2s_rx_chk #(.SAMPLE_W(SAMPLE_W), .MIN_BITS(MIN_BITS)) u_chk (
   .clk(clk), .rst_n(rst_n), .left_o(left_o), .right_o(right_o),
   .len_o(len_o), .frame_vld_o(frame_vld_o), .fmt_err_o(fmt_err_o));

// File: tb/i2s_autolen_rx_tb.sv
module i2s_autolen_rx_tb;
   localparam int HALF = 20;

   typedef struct packed {
      logic [5:0]  slot;
      logic [31:0] lw;
      logic [31:0] rw;
      logic [23:0] el;
      logic [23:0] er;
      logic [4:0]  elen;
   } vec_t;

   localparam int NV = 6;
   localparam vec_t VECS [NV] = '{
      '{6'd24, 32'hA5C3E100, 32'h12345600, 24'hA5C3E1, 24'h123456, 5'd24},
      '{6'd16, 32'hBEEF0000, 32'h80010000, 24'hBEEF00, 24'h800100, 5'd16},
      '{6'd20, 32'hFFFFF000, 32'h12345000, 24'hFFFFF0, 24'h123450, 5'd20},
      '{6'd32, 32'hC0FFEE77, 32'h7E5A3CFF, 24'hC0FFEE, 24'h7E5A3C, 5'd24},
      '{6'd18, 32'h80000000, 32'h0000C000, 24'h800000, 24'h0000C0, 5'd18},
      '{6'd17, 32'h55558000, 32'hFFFFFFFF, 24'h555580, 24'hFFFF80, 5'd17}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic sclk = 1'b0, lrck = 1'b0, sdata = 1'b0;
   logic [23:0] left_o, right_o;
   logic [4:0]  len_o;
   logic        frame_vld_o, fmt_err_o;
   int total = 0, bad = 0, vld_cnt = 0, err_cnt = 0;

   always #2 clk = ~clk;

   i2s_autolen_rx u_dut (
      .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .lrck_i(lrck), .sdata_i(sdata),
      .left_o(left_o), .right_o(right_o), .len_o(len_o),
      .frame_vld_o(frame_vld_o), .fmt_err_o(fmt_err_o));

   always @(negedge clk) begin
      if (rst_n && frame_vld_o) vld_cnt++;
      if (rst_n && fmt_err_o) err_cnt++;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bit_out(input logic lr, input logic d);
      sdata = d; lrck = lr;
      #(HALF); sclk = 1'b1;
      #(HALF); sclk = 1'b0;
   endtask

   task automatic send_half(input logic ch, input logic [31:0] v, input int n, input logic nxt);
      for (int i = 0; i < n; i++) bit_out((i == n-1) ? nxt : ch, v[31-i]);
   endtask

   task automatic send_frame(input logic [31:0] l, input logic [31:0] r, input int nl, input int nr);
      send_half(1'b0, l, nl, 1'b1);
      send_half(1'b1, r, nr, 1'b0);
      repeat (30) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic preamble();
      for (int i = 0; i < 5; i++) bit_out(1'b1, 1'b1);
      bit_out(1'b0, 1'b1);
      repeat (30) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      #(200000 * 4);
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int v0, e0;
      logic [23:0] hl, hr;
      repeat (5) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      check("R1 left reset", 32'(left_o), 32'h0);
      check("R1 right reset", 32'(right_o), 32'h0);
      check("R1 len reset", 32'(len_o), 32'h0);
      rst_n = 1'b1;
      preamble();
      // R1: partial word before first transition is dropped
      check("R1 no strobe in preamble", 32'(vld_cnt + err_cnt), 32'h0);

      // table walk: R2 R3 R4 R5 R7
      for (int k = 0; k < NV; k++) begin
         v0 = vld_cnt;
         send_frame(VECS[k].lw, VECS[k].rw, int'(VECS[k].slot), int'(VECS[k].slot));
         check("R6 one valid per frame", 32'(vld_cnt - v0), 32'd1);
         check("R2/R7 left word", 32'(left_o), 32'(VECS[k].el));
         check("R2/R7 right word", 32'(right_o), 32'(VECS[k].er));
         check("R4/R5 length", 32'(len_o), 32'(VECS[k].elen));
      end
      check("R3 no errors on good frames", 32'(err_cnt), 32'h0);

      // R8 / R9: short left half (12 bits)
      hl = left_o; hr = right_o; v0 = vld_cnt; e0 = err_cnt;
      send_frame(32'hDEADBEEF, 32'h11111111, 12, 24);
      check("R8 short left flags error", 32'(err_cnt - e0), 32'd1);
      check("R9 short left no valid", 32'(vld_cnt - v0), 32'd0);
      check("R8 left held", 32'(left_o), 32'(hl));
      check("R8 right held", 32'(right_o), 32'(hr));

      // R8: short right half (15 bits)
      v0 = vld_cnt; e0 = err_cnt;
      send_frame(32'h22222222, 32'h33333333, 24, 15);
      check("R8 short right flags error", 32'(err_cnt - e0), 32'd1);
      check("R8 short right no valid", 32'(vld_cnt - v0), 32'd0);

      // R9: recovery
      v0 = vld_cnt;
      send_frame(32'h0F0F0F00, 32'hF0F0F000, 24, 24);
      check("R9 recovery valid", 32'(vld_cnt - v0), 32'd1);
      check("R9 recovery left", 32'(left_o), 32'h0F0F0F);
      check("R9 recovery right", 32'(right_o), 32'hF0F0F0);

      // R1: mid-run reset clears outputs
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 left after reset", 32'(left_o), 32'h0);
      check("R1 len after reset", 32'(len_o), 32'h0);
      rst_n = 1'b1;
      v0 = vld_cnt; e0 = err_cnt;
      preamble();
      send_frame(32'h01234500, 32'h6789AB00, 24, 24);
      check("R1 resumes after reset", 32'(vld_cnt - v0), 32'd1);
      check("R1 no error after reset", 32'(err_cnt - e0), 32'd0);
      check("R7 left after reset", 32'(left_o), 32'h012345);
      check("R7 right after reset", 32'(right_o), 32'h6789AB);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule